// File: doc/BRIEF.md
# Unsigned Constant-Divisor Divider

This block divides a W-bit unsigned dividend by a divisor fixed when the design is elaborated. It returns both the quotient and the remainder on registered outputs one clock after the dividend is presented. It has no iterative divider. The quotient comes from a multiply by a precomputed reciprocal constant, followed by constant shifts. Constant functions pick the constants from the divisor parameter. The remainder is the dividend minus the quotient times the divisor.

For each divisor, elaboration picks one of five forms. A divisor of zero gives defined zero outputs. A power of two (including one) becomes a plain shift and mask with no multiplier. Other divisors use a direct reciprocal multiply when a magic constant of at most W bits is exact. Failing that, an even divisor first shifts the dividend down by its trailing zeros. The last resort is a round-up add fixup. Widths from 2 to 32 bits are supported.

Top module: `cdiv_top`

## Requirements
- R1: The synchronous active-high reset clears both outputs to zero. Outputs are registered, so a dividend presented before a rising edge appears at the outputs after that edge.
- R2: For a nonzero divisor D, the quotient output equals floor(x / D) for every W-bit dividend x.
- R3: For a nonzero divisor, the remainder output equals (x - q*D) truncated to W bits and always lies in the range 0 to D-1.
- R4: With D = 0, both quotient and remainder are zero for every dividend.
- R5: When D is a power of two (1 included), the quotient is x shifted right by log2(D) and the remainder is x masked to its low log2(D) bits, with no multiplier.
- R6: Direct form: the plan takes the smallest post-shift s in 0..W for which m = ceil(2^(W+s)/D) is below 2^W and m*D - 2^(W+s) is at most 2^s. The quotient is then the upper W bits of x*m, shifted right by s. At W=8 this gives m=171, s=1 for D=3 and m=205, s=3 for D=10. The plan records the mode value CD_DIRECT.
- R7: Fixup form: when no direct or pre-shift plan exists, let l = ceil(log2 D) and m = ceil(2^(W+l)/D) - 2^W. With h the upper W bits of x*m, the quotient is (h + ((x - h) >> 1)) >> (l-1). At W=8, D=7 gives m=37 and mode CD_FIXUP.
- R8: Pre-shift form: when the direct form fails and D has t > 0 trailing zero bits, the search is repeated for D >> t with the error bound raised to 2^(s+t). The dividend is shifted right by t before the multiply. At W=8, D=14 gives pre-shift 1, m=147, post-shift 2 and mode CD_PRESHIFT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dividend_i | input | W | Unsigned dividend |
| quotient_o | output | W | Registered quotient |
| remainder_o | output | W | Registered remainder |

## Verification
The bench applies every 8-bit dividend to eight instances at once, one for each of the divisors 0, 1, 3, 7, 10, 14, 128 and 255. Each divisor reaches a different elaboration mode: zero, shift, direct, fixup and pre-shift. A fault in any one path therefore shows up at its own instance while the others stay correct. A 12-bit instance with divisor 100 is swept over all 4096 dividends, which tests constant selection at another width. Two 32-bit instances receive scattered values plus the extremes (zero, all ones, the top bit alone, values just around the divisor), where a truncated product or a wrong fixup would show. The plan constants for 3, 7, 10 and 14 are compared against the stated magic values.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  typedef enum logic [2:0] {
    CD_ZERO,
    CD_SHIFT,
    CD_DIRECT,
    CD_PRESHIFT,
    CD_FIXUP
  } cd_mode_e;

  typedef struct packed {
    cd_mode_e    mode;
    logic [31:0] magic;
    logic [5:0]  pre;
    logic [5:0]  post;
  } cd_plan_t;

  // floor(log2(v)) for v > 0
  function automatic int unsigned cd_log2(longint unsigned v);
    int unsigned r;
    r = 0;
    for (int unsigned i = 0; i < 64; i++)
      if ((v >> i) != 0) r = i;
    return r;
  endfunction

  // Search for an exact reciprocal with at most w magic bits.
  // slack widens the error bound when the dividend is pre-shifted.
  function automatic cd_plan_t cd_try(int unsigned w, longint unsigned d,
                                      int unsigned slack);
    cd_plan_t    p;
    logic [127:0] pw, m, e, dd;
    bit          found;
    p     = '0;
    p.mode = CD_FIXUP;
    found = 1'b0;
    dd    = 128'(d);
    for (int unsigned s = 0; s <= w; s++) begin
      if (!found) begin
        pw = 128'd1 << (w + s);
        m  = (pw + dd - 128'd1) / dd;
        e  = m * dd - pw;
        if ((m < (128'd1 << w)) && (e <= (128'd1 << (s + slack)))) begin
          found   = 1'b1;
          p.mode  = CD_DIRECT;
          p.magic = m[31:0];
          p.post  = 6'(s);
        end
      end
    end
    return p;
  endfunction

  function automatic cd_plan_t cd_make_plan(int unsigned w, longint unsigned d);
    cd_plan_t     p, q;
    int unsigned  tz, l;
    logic [127:0] m;
    p = '0;
    if (d == 0) begin
      p.mode = CD_ZERO;
    end else if ((d & (d - 64'd1)) == 0) begin
      p.mode = CD_SHIFT;
      p.post = 6'(cd_log2(d));
    end else begin
      p = cd_try(w, d, 0);
      if (p.mode != CD_DIRECT) begin
        tz = 0;
        for (int unsigned i = 0; i < 64; i++)
          if (((d >> i) << i) == d) tz = i;
        if (tz > 0) begin
          q = cd_try(w - tz, d >> tz, tz);
          // magic is bounded by w bits, the dividend after the shift by w-tz
          q = cd_try(w, d >> tz, tz);
          if (q.mode == CD_DIRECT) begin
            p      = q;
            p.mode = CD_PRESHIFT;
            p.pre  = 6'(tz);
          end
        end
      end
      if (p.mode == CD_FIXUP) begin
        l       = cd_log2(d) + 1;
        m       = ((128'd1 << (w + l)) + 128'(d) - 128'd1) / 128'(d);
        m       = m - (128'd1 << w);
        p.magic = m[31:0];
        p.pre   = '0;
        p.post  = 6'(l - 1);
      end
    end
    return p;
  endfunction

endpackage

// File: rtl/cdiv_mulhi.sv
module cdiv_mulhi #(
  parameter int          W     = 8,
  parameter logic [31:0] MAGIC = 32'd1
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] hi
);
  localparam int W2 = 2 * W;
  localparam logic [W2-1:0] MAGIC_WIDE = W2'(MAGIC[W-1:0]);

  logic [W2-1:0] prod;
  assign prod = W2'(a) * MAGIC_WIDE;
  assign hi   = prod[W2-1:W];
endmodule

// File: rtl/cdiv_quot.sv
module cdiv_quot
  import cdiv_pkg::*;
#(
  parameter int              W       = 8,
  parameter longint unsigned DIVISOR = 7
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] q
);
  localparam cd_plan_t PLAN = cd_make_plan(W, DIVISOR);
  localparam int       PRE  = int'(PLAN.pre);
  localparam int       POST = int'(PLAN.post);

  if (PLAN.mode == CD_ZERO) begin : g_zero
    assign q = '0;
  end else if (PLAN.mode == CD_SHIFT) begin : g_shift
    assign q = x >> POST;
  end else begin : g_mul
    logic [W-1:0] src, hi;
    assign src = x >> PRE;
    cdiv_mulhi #(.W(W), .MAGIC(PLAN.magic)) u_mh (
      .a  (src),
      .hi (hi)
    );
    if (PLAN.mode == CD_FIXUP) begin : g_fix
      logic [W-1:0] half;
      assign half = (x - hi) >> 1;
      assign q    = (hi + half) >> POST;
    end else begin : g_plain
      assign q = hi >> POST;
    end
  end
endmodule

// File: rtl/cdiv_rem.sv
module cdiv_rem
  import cdiv_pkg::*;
#(
  parameter int              W       = 8,
  parameter longint unsigned DIVISOR = 7
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] q,
  output logic [W-1:0] r
);
  localparam cd_plan_t PLAN = cd_make_plan(W, DIVISOR);

  if (PLAN.mode == CD_ZERO) begin : g_zero
    assign r = '0;
  end else if (PLAN.mode == CD_SHIFT) begin : g_mask
    localparam logic [W-1:0] MASK = W'(DIVISOR - 64'd1);
    assign r = x & MASK;
  end else begin : g_sub
    localparam logic [W-1:0] DV = W'(DIVISOR);
    logic [W-1:0] back;
    assign back = q * DV;
    assign r    = x - back;
  end
endmodule

// File: rtl/cdiv_top.sv
module cdiv_top #(
  parameter int              W       = 8,
  parameter longint unsigned DIVISOR = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] dividend_i,
  output logic [W-1:0] quotient_o,
  output logic [W-1:0] remainder_o
);
  logic [W-1:0] q_c, r_c;

  cdiv_quot #(.W(W), .DIVISOR(DIVISOR)) u_quot (
    .x (dividend_i),
    .q (q_c)
  );

  cdiv_rem #(.W(W), .DIVISOR(DIVISOR)) u_rem (
    .x (dividend_i),
    .q (q_c),
    .r (r_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      quotient_o  <= '0;
      remainder_o <= '0;
    end else begin
      quotient_o  <= q_c;
      remainder_o <= r_c;
    end
  end
endmodule

// File: rtl/cdiv_checker.sv
module cdiv_checker
  import cdiv_pkg::*;
#(
  parameter int              W       = 8,
  parameter longint unsigned DIVISOR = 7
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] dividend_i,
  input logic [W-1:0] quotient_o,
  input logic [W-1:0] remainder_o
);
  localparam cd_plan_t PLAN = cd_make_plan(W, DIVISOR);
  localparam int       W2   = 2 * W;
  localparam logic [W2-1:0] DV2 = W2'(DIVISOR);
  localparam logic [W-1:0]  DV  = W'(DIVISOR);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (quotient_o == '0 && remainder_o == '0));

  if (PLAN.mode == CD_ZERO) begin : g_zero
    assert_zero_divisor_R4: assert property (@(posedge clk) disable iff (rst)
      (quotient_o == '0 && remainder_o == '0));
  end else begin : g_nz
    assert_rem_below_div_R3: assert property (@(posedge clk) disable iff (rst)
      remainder_o < DV);
    assert_recompose_R2: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |->
        (W2'(quotient_o) * DV2 + W2'(remainder_o) == W2'($past(dividend_i))));
    if (PLAN.mode == CD_SHIFT) begin : g_pow
      assert_shift_quot_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> quotient_o == ($past(dividend_i) >> int'(PLAN.post)));
    end
  end
endmodule

bind cdiv_top cdiv_checker #(.W(W), .DIVISOR(DIVISOR)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .dividend_i  (dividend_i),
  .quotient_o  (quotient_o),
  .remainder_o (remainder_o)
);

// File: tb/sim_cdiv_top.sv
module sim_cdiv_top;
  import cdiv_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int N8 = 8;
  localparam longint unsigned DIVS8 [N8] = '{3, 0, 1, 7, 10, 14, 128, 255};
  localparam longint unsigned D12  = 100;
  localparam longint unsigned D32A = 7;
  localparam longint unsigned D32B = 1000003;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]  din8  = '0;
  logic [11:0] din12 = '0;
  logic [31:0] din32 = '0;
  logic [7:0]  q8 [N8];
  logic [7:0]  r8 [N8];
  logic [11:0] q12, r12;
  logic [31:0] q32a, r32a, q32b, r32b;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  ended  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cdiv_top #(.W(8), .DIVISOR(DIVS8[0])) u0 (.clk(clk), .rst(rst), .dividend_i(din8), .quotient_o(q8[0]), .remainder_o(r8[0]));
  cdiv_top #(.W(8), .DIVISOR(DIVS8[1])) u1 (.clk(clk), .rst(rst), .dividend_i(din8), .quotient_o(q8[1]), .remainder_o(r8[1]));
  cdiv_top #(.W(8), .DIVISOR(DIVS8[2])) u2 (.clk(clk), .rst(rst), .dividend_i(din8), .quotient_o(q8[2]), .remainder_o(r8[2]));
  cdiv_top #(.W(8), .DIVISOR(DIVS8[3])) u3 (.clk(clk), .rst(rst), .dividend_i(din8), .quotient_o(q8[3]), .remainder_o(r8[3]));
  cdiv_top #(.W(8), .DIVISOR(DIVS8[4])) u4 (.clk(clk), .rst(rst), .dividend_i(din8), .quotient_o(q8[4]), .remainder_o(r8[4]));
  cdiv_top #(.W(8), .DIVISOR(DIVS8[5])) u5 (.clk(clk), .rst(rst), .dividend_i(din8), .quotient_o(q8[5]), .remainder_o(r8[5]));
  cdiv_top #(.W(8), .DIVISOR(DIVS8[6])) u6 (.clk(clk), .rst(rst), .dividend_i(din8), .quotient_o(q8[6]), .remainder_o(r8[6]));
  cdiv_top #(.W(8), .DIVISOR(DIVS8[7])) u7 (.clk(clk), .rst(rst), .dividend_i(din8), .quotient_o(q8[7]), .remainder_o(r8[7]));
  cdiv_top #(.W(12), .DIVISOR(D12)) u8 (.clk(clk), .rst(rst), .dividend_i(din12), .quotient_o(q12), .remainder_o(r12));
  cdiv_top #(.W(32), .DIVISOR(D32A)) u9 (.clk(clk), .rst(rst), .dividend_i(din32), .quotient_o(q32a), .remainder_o(r32a));
  cdiv_top #(.W(32), .DIVISOR(D32B)) u10 (.clk(clk), .rst(rst), .dividend_i(din32), .quotient_o(q32b), .remainder_o(r32b));

  task automatic chk(string req, string what, longint unsigned got, longint unsigned exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // requirement whose path a given 8-bit divisor exercises
  function automatic string qtag(longint unsigned d);
    if (d == 0) return "R4";
    if ((d & (d - 1)) == 0) return "R5";
    if (d == 7) return "R7";
    if (d == 14) return "R8";
    return "R2";
  endfunction

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic check_all(longint unsigned x8, longint unsigned x12, longint unsigned x32);
    for (int k = 0; k < N8; k++) begin
      longint unsigned d = DIVS8[k];
      chk(qtag(d), $sformatf("q d=%0d x=%0d", d, x8), q8[k], (d == 0) ? 0 : x8 / d);
      chk((d == 0) ? "R4" : "R3", $sformatf("r d=%0d x=%0d", d, x8), r8[k], (d == 0) ? 0 : x8 % d);
    end
    chk("R2", $sformatf("q12 x=%0d", x12), q12, x12 / D12);
    chk("R3", $sformatf("r12 x=%0d", x12), r12, x12 % D12);
    chk("R7", $sformatf("q32/7 x=%0d", x32), q32a, x32 / D32A);
    chk("R3", $sformatf("r32/7 x=%0d", x32), r32a, x32 % D32A);
    chk("R2", $sformatf("q32/big x=%0d", x32), q32b, x32 / D32B);
    chk("R3", $sformatf("r32/big x=%0d", x32), r32b, x32 % D32B);
  endtask

  task automatic check_reset_zero();
    for (int k = 0; k < N8; k++) begin
      chk("R1", "reset q8", q8[k], 0);
      chk("R1", "reset r8", r8[k], 0);
    end
    chk("R1", "reset q32", q32b, 0);
    chk("R1", "reset r32", r32b, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    cd_plan_t p;
    logic [31:0] edge32 [6];
    edge32 = '{32'hFFFF_FFFF, 32'h8000_0000, 32'd7, 32'd6, 32'd1000002, 32'd1000003};

    // R1: outputs cleared while reset is held
    din8 = 8'hFF; din12 = 12'hFFF; din32 = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_zero();

    // R6 R7 R8: plan constants
    p = cd_make_plan(8, 3);
    chk("R6", "magic d=3", p.magic, 171);
    chk("R6", "post d=3", p.post, 1);
    chk("R6", "mode d=3", p.mode, CD_DIRECT);
    p = cd_make_plan(8, 10);
    chk("R6", "magic d=10", p.magic, 205);
    chk("R6", "post d=10", p.post, 3);
    p = cd_make_plan(8, 7);
    chk("R7", "magic d=7", p.magic, 37);
    chk("R7", "mode d=7", p.mode, CD_FIXUP);
    p = cd_make_plan(8, 14);
    chk("R8", "mode d=14", p.mode, CD_PRESHIFT);
    chk("R8", "pre d=14", p.pre, 1);
    chk("R8", "magic d=14", p.magic, 147);
    chk("R8", "post d=14", p.post, 2);

    rst = 1'b0;
    // R2 R3: full sweep, one vector per cycle
    for (int v = 0; v < 4096; v++) begin
      din8  = 8'(v);
      din12 = 12'(v);
      din32 = 32'(v) * 32'h9E37_79B1;
      @(negedge clk);
      check_all(longint'(din8), longint'(din12), longint'(din32));
    end
    // R7 R2: 32-bit extremes
    for (int i = 0; i < 6; i++) begin
      din32 = edge32[i];
      @(negedge clk);
      check_all(longint'(din8), longint'(din12), longint'(din32));
    end

    // R1: reset in mid-run clears again
    rst = 1'b1;
    @(negedge clk);
    check_reset_zero();
    rst = 1'b0;
    @(negedge clk);
    check_all(longint'(din8), longint'(din12), longint'(din32));

    finish_run();
  end
endmodule